// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. Each cycle it combines the accumulator value with one operand under a 3-bit operation select, and presents the result at once on a combinational output. The surrounding control logic supplies the current carry flag for the carry-in and borrow-in forms. It also raises an update enable for each operation it wants recorded.

A strobe marks results that should be written back to the accumulator. Compare computes a difference for its flags only, so it never raises the strobe. The block holds a packed status byte with five flags: sign, zero, half-carry, even parity and carry/borrow. It loads this byte on the rising clock edge whenever the update enable is high.

The operand path has no back-pressure. An operation is accepted in every cycle where the update enable is high, so the caller never waits. The caller must latch the result in the same cycle in which the strobe is high.

Top module: `acc_alu`

## Requirements
- R1: Select 0 (add) gives result = (acc + opnd) mod 256 and carry = bit 8 of that sum. Select 1 (add with carry) also adds `cy_in`.
- R2: Select 2 (subtract) gives result = (acc - opnd) mod 256, and select 3 also subtracts `cy_in`. Carry is 1 exactly when the true difference is negative (a borrow).
- R3: Select 5 (AND), 6 (OR) and 7 (XOR) give the bitwise result and clear carry. Half-carry is set to 1 after AND and cleared after OR or XOR.
- R4: After an update, the sign flag (bit 7) equals bit 7 of the result.
- R5: After an update, the zero flag (bit 6) is 1 if and only if all eight result bits are 0.
- R6: For the arithmetic selects 0 to 4, half-carry (bit 4) is the carry out of the low nibble for add and the borrow out of the low nibble for subtract and compare. Each form uses the same carry-in as its full-width operation.
- R7: After an update, the parity flag (bit 2) is 1 if and only if the result holds an even number of 1 bits.
- R8: Flag bits 5, 3 and 1 always read 0, and carry sits at bit 0.
- R9: Select 4 (compare) drives the acc - opnd difference on `result` and updates every flag as select 2 would, but it keeps `wr_stb` low.
- R10: `wr_stb` is high exactly when `upd_en` is high and the select is not 4.
- R11: The flag byte changes only on a rising edge with `upd_en` high and otherwise holds its value. A synchronous `rst` clears it to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand |
| op | input | 3 | Operation select (0 add, 1 add+carry, 2 sub, 3 sub+borrow, 4 compare, 5 and, 6 or, 7 xor) |
| cy_in | input | 1 | Current carry flag used by selects 1 and 3 |
| upd_en | input | 1 | Record this operation in the flag byte |
| result | output | 8 | Combinational result |
| wr_stb | output | 1 | Accumulator write strobe |
| flags | output | 8 | Packed status byte |

## Verification
The assertions relate the registered flag byte to the result and select from the previous cycle. They therefore assume that `acc`, `opnd`, `op` and `upd_en` are known and held steady around each rising edge, and that `rst` is synchronous. The bench drives every input on the falling edge and holds it through the following rising edge. It draws `op` from the full 3-bit range so that no illegal select can appear. It randomises `upd_en` at about three in four, which exercises both the hold path and the load path.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int F_CY = 0;
  localparam int F_P  = 2;
  localparam int F_AC = 4;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         co,
  output logic         hc
);
  localparam int NW = W / 2;

  logic         cbit;
  logic [W:0]   full;
  logic [NW:0]  half;

  assign cbit = use_cin & cin;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cbit};
      half = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cbit};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cbit};
      half = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cbit};
    end
  end

  assign res = full[W-1:0];
  assign co  = full[W];
  assign hc  = half[NW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (sel)
      2'd1:    res = a & b;
      2'd2:    res = a | b;
      2'd3:    res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      acc,
  input  logic [W-1:0]      opnd,
  input  logic [2:0]        op,
  input  logic              cy_in,
  input  logic              upd_en,
  output logic [W-1:0]      result,
  output logic              wr_stb,
  output logic [FLAG_W-1:0] flags
);
  alu_op_e      op_e;
  logic         is_arith, is_sub, use_cin;
  logic [W-1:0] ar_res, lg_res;
  logic         ar_co, ar_hc;
  logic [FLAG_W-1:0] flag_d;
  logic         nf_cy, nf_ac;

  assign op_e     = alu_op_e'(op);
  assign is_arith = (op_e == OP_ADD) || (op_e == OP_ADC) || (op_e == OP_SUB) ||
                    (op_e == OP_SBB) || (op_e == OP_CMP);
  assign is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
  assign use_cin  = (op_e == OP_ADC) || (op_e == OP_SBB);

  alu_arith #(.W(W)) u_arith (
    .a(acc), .b(opnd), .sub(is_sub), .use_cin(use_cin), .cin(cy_in),
    .res(ar_res), .co(ar_co), .hc(ar_hc)
  );

  alu_logic #(.W(W)) u_logic (
    .a(acc), .b(opnd), .sel(op[1:0]), .res(lg_res)
  );

  assign result = is_arith ? ar_res : lg_res;
  assign wr_stb = upd_en && (op_e != OP_CMP);

  always_comb begin
    if (is_arith) begin
      nf_cy = ar_co;
      nf_ac = ar_hc;
    end else begin
      nf_cy = 1'b0;
      nf_ac = (op_e == OP_AND);
    end
    flag_d       = '0;
    flag_d[F_S]  = result[W-1];
    flag_d[F_Z]  = (result == '0);
    flag_d[F_AC] = nf_ac;
    flag_d[F_P]  = ~^result;
    flag_d[F_CY] = nf_cy;
  end

  alu_flag_reg #(.FW(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .en(upd_en), .d(flag_d), .q(flags)
  );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] op,
  input logic       upd_en,
  input logic [7:0] result,
  input logic       wr_stb,
  input logic [7:0] flags
);
  p_reset_clear_r11: assert property (@(posedge clk) rst |=> flags == 8'h00);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(flags));

  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> flags[7] == $past(result[7]));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> flags[6] == ($past(result) == 8'h00));

  p_parity_r7: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> flags[2] == ($countones($past(result)) % 2 == 0));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (flags[5] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b0));

  p_cmp_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4) |-> !wr_stb);

  p_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op != 3'd4) |-> wr_stb);

  p_logic_clear_cy_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op >= 3'd5) |=> !flags[0]);
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst(rst), .op(op), .upd_en(upd_en),
  .result(result), .wr_stb(wr_stb), .flags(flags)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc = '0, opnd = '0;
  logic [2:0] op = '0;
  logic       cy_in = 1'b0, upd_en = 1'b0;
  logic [7:0] result, flags;
  logic       wr_stb;

  int n_vec = 0;
  int n_err = 0;
  logic [7:0] exp_flags = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .acc(acc), .opnd(opnd), .op(op), .cy_in(cy_in),
    .upd_en(upd_en), .result(result), .wr_stb(wr_stb), .flags(flags)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected result and flag byte, from the requirement text
  function automatic void model(input logic [2:0] o, input logic [7:0] a,
                                input logic [7:0] b, input logic c,
                                output logic [7:0] r, output logic [7:0] f);
    int ai = a, bi = b, ci = 0, t, lo;
    logic cy, ac;
    if (o == 3'd1 || o == 3'd3) ci = c;
    cy = 0; ac = 0;
    case (o)
      3'd0, 3'd1: begin
        t = ai + bi + ci; lo = (ai % 16) + (bi % 16) + ci;
        cy = (t > 255); ac = (lo > 15); r = t[7:0];
      end
      3'd2, 3'd3, 3'd4: begin
        t = ai - bi - ci; lo = (ai % 16) - (bi % 16) - ci;
        cy = (t < 0); ac = (lo < 0); r = t[7:0];
      end
      3'd5: begin r = a & b; ac = 1; end
      3'd6: r = a | b;
      default: r = a ^ b;
    endcase
    f = {r[7], (r == 8'h00), 1'b0, ac, 1'b0, ($countones(r) % 2 == 0), 1'b0, cy};
  endfunction

  task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic en);
    logic [7:0] er, ef;
    @(negedge clk);
    op = o; acc = a; opnd = b; cy_in = c; upd_en = en;
    model(o, a, b, c, er, ef);
    #1;
    if (o <= 3'd1)      chk(result == er, "R1 result", result, er);
    else if (o <= 3'd3) chk(result == er, "R2 result", result, er);
    else if (o == 3'd4) chk(result == er, "R9 result", result, er);
    else                chk(result == er, "R3 result", result, er);
    chk(wr_stb == (en && o != 3'd4), "R10 strobe", wr_stb, en && o != 3'd4);
    if (en) exp_flags = ef;
    @(posedge clk); #1;
    if (en) begin
      chk(flags[7] == exp_flags[7], "R4 sign", flags, exp_flags);
      chk(flags[6] == exp_flags[6], "R5 zero", flags, exp_flags);
      chk(flags[2] == exp_flags[2], "R7 parity", flags, exp_flags);
      chk(flags[4] == exp_flags[4], o <= 3'd4 ? "R6 halfcarry" : "R3 halfcarry", flags, exp_flags);
      chk(flags[0] == exp_flags[0], o <= 3'd1 ? "R1 carry" : (o <= 3'd4 ? "R2 borrow" : "R3 carry"), flags, exp_flags);
      chk((flags & 8'h2A) == 8'h00, "R8 unused", flags, exp_flags);
    end else begin
      chk(flags == exp_flags, "R11 hold", flags, exp_flags);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_0085;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 chk(flags == 8'h00, "R11 reset", flags, 0);
    @(negedge clk); rst = 1'b0;

    apply(3'd0, 8'hFF, 8'h01, 1'b0, 1'b1);  // zero, carry, halfcarry
    apply(3'd1, 8'h0F, 8'h00, 1'b1, 1'b1);  // adc nibble carry
    apply(3'd2, 8'h00, 8'h01, 1'b0, 1'b1);  // borrow, 0xFF
    apply(3'd3, 8'h10, 8'h0F, 1'b1, 1'b1);  // sbb to zero
    apply(3'd4, 8'h42, 8'h42, 1'b0, 1'b1);  // compare equal
    apply(3'd4, 8'h10, 8'h20, 1'b1, 1'b1);  // compare less
    apply(3'd5, 8'hF0, 8'h0F, 1'b0, 1'b1);  // and -> zero, AC=1
    apply(3'd6, 8'h80, 8'h01, 1'b0, 1'b1);  // or
    apply(3'd7, 8'hAA, 8'hAA, 1'b0, 1'b1);  // xor zero
    apply(3'd0, 8'h7F, 8'h01, 1'b1, 1'b0);  // disabled -> hold
    apply(3'd1, 8'h80, 8'h80, 1'b0, 1'b1);  // adc no cin

    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom();
      apply(rv[2:0], rv[10:3], rv[18:11], rv[19], rv[21:20] != 2'b00);
    end

    @(negedge clk); rst = 1'b1; upd_en = 1'b1;
    @(posedge clk); #1;
    chk(flags == 8'h00, "R11 reset", flags, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule